// File: doc/BRIEF.md
# Masked Dual-Bank GPIO with Transmit/Receive Override

This block drives two 16-bit general-purpose I/O banks, one on the transmit side and one on the receive side of a radio front end. Each bank holds a direction register (output enable) and a data register. Both are updated by an atomic masked write: one 32-bit word carries a per-bit mask in its upper half and new values in its lower half. Only the bits the mask selects change, so independent pieces of software can each own a few pins without a read-modify-write race.

Each bank also has an automatic transmit/receive override with three 16-bit registers: a select mask, a transmit pattern and a receive pattern. On every selected bit the driven value follows the `tx_active` input. It takes the transmit pattern while transmitting and the receive pattern otherwise. The typical use is an antenna switch bit that is driven 0 during transmit and 1 during receive. A dedicated shutdown address turns every pin of both banks into an input in one write. A combinational readback word reports the state of each pin. For a driven pin this is its own output value, and for a tri-stated pin it is the external level.

Writes land on the rising clock edge. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `gpio_tr_top`

## Requirements
- R1: After reset every output enable, data bit and override register of both banks is 0, so `tx_pin_oe`, `rx_pin_oe`, `tx_pin_out` and `rx_pin_out` are all 0.
- R2: A write to a bank's output-enable register (bank offset 0) takes `wr_data[15:0]` into the bits where `wr_data[31:16]` is 1 and leaves the other bits unchanged.
- R3: A write to a bank's data register (bank offset 1) follows the same masked rule as R2.
- R4: `wr_addr[3]` picks the bank: 0 for transmit, 1 for receive. A write to one bank leaves every register of the other bank unchanged.
- R5: Each bank drives `pin_out = (sel & (tx_active ? txpat : rxpat)) | (~sel & data)`. Here sel, txpat and rxpat are the override registers at bank offsets 2, 3 and 4.
- R6: An override register write loads all 16 bits from `wr_data[15:0]` and ignores `wr_data[31:16]`.
- R7: The override never changes a pin's output enable. `pin_oe` equals the output-enable register.
- R8: `rd_data[31:16]` holds the receive-bank pin states and `rd_data[15:0]` the transmit-bank pin states. Each bit is the driven output when its enable is 1 and the external input when it is 0.
- R9: A write to address 15 clears the output enables of both banks and keeps their data and override registers.
- R10: A write to an unmapped address (bank offsets 5 to 7, except address 15) changes no register.
- R11: A write is visible on the pins and in the readback in the cycle after the clock edge that samples it. Without a write the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register address: bit 3 is the bank, bits 2:0 the register |
| wr_data | input | 32 | Mask in [31:16], value in [15:0] |
| tx_active | input | 1 | Selects the transmit pattern for overridden bits |
| tx_pin_in | input | 16 | External level of the transmit-bank pins |
| rx_pin_in | input | 16 | External level of the receive-bank pins |
| tx_pin_out | output | 16 | Driven value of the transmit-bank pins |
| tx_pin_oe | output | 16 | Output enable of the transmit-bank pins |
| rx_pin_out | output | 16 | Driven value of the receive-bank pins |
| rx_pin_oe | output | 16 | Output enable of the receive-bank pins |
| rd_data | output | 32 | Pin-state readback, receive bank high, transmit bank low |

## Verification
The clocked properties assume that `wr_en`, `wr_addr`, `tx_active` and the pin inputs are known 0/1 values at every sampling edge once the synchronized reset has been released. They also assume the pin inputs change only between edges. The stimulus meets this: every input is given a defined value before reset is removed and changes only on the falling clock edge. Each test cycle carries at most one write, so the shutdown address never meets a bank write in the same cycle.

// File: rtl/gpio_tr_pkg.sv
package gpio_tr_pkg;

  // Register offsets inside one bank (address bits 2:0)
  typedef enum logic [2:0] {
    OFS_OE    = 3'd0,
    OFS_DATA  = 3'd1,
    OFS_OVSEL = 3'd2,
    OFS_OVTX  = 3'd3,
    OFS_OVRX  = 3'd4
  } bank_ofs_e;

  localparam int NUM_BANK_REGS = 5;
  localparam int NUM_MASKED    = 2;  // offsets below this use the masked format
  localparam int OFS_W         = 3;
  localparam int NUM_BANKS     = 2;  // 0 = transmit, 1 = receive

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_val,
  input  logic         clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = wr_en | clr;
    q_nxt = q_r;
    if (clr) begin
      q_nxt = '0;
    end else if (wr_en) begin
      q_nxt = (q_r & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // Bits outside the mask survive a write.
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> ((q_r & ~$past(wr_mask)) == ($past(q_r) & ~$past(wr_mask))));

  // Bits inside the mask take the new value.
  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> ((q_r & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask))));

  // No write, no change.
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(q_r));

  // A clear empties the register.
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_r == '0));

endmodule

// File: rtl/gpio_override_mux.sv
module gpio_override_mux #(
  parameter int W = 16
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] tx_pat,
  input  logic [W-1:0] rx_pat,
  input  logic         tx_active,
  output logic [W-1:0] pin_out
);

  logic [W-1:0] pat;

  always_comb begin
    pat     = tx_active ? tx_pat : rx_pat;
    pin_out = (sel & pat) | (~sel & data);
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_tr_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_wr,
  input  logic [OFS_W-1:0]   wr_ofs,
  input  logic [2*PIN_W-1:0] wr_data,
  input  logic               shutdown,
  input  logic               tx_active,
  input  logic [PIN_W-1:0]   pin_in,
  output logic [PIN_W-1:0]   pin_out,
  output logic [PIN_W-1:0]   pin_oe,
  output logic [PIN_W-1:0]   rb_state
);

  logic [PIN_W-1:0] wr_val;
  logic [PIN_W-1:0] wr_mask;
  logic [PIN_W-1:0] reg_q [NUM_BANK_REGS];

  assign wr_val  = wr_data[PIN_W-1:0];
  assign wr_mask = wr_data[2*PIN_W-1:PIN_W];

  for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_reg
    logic reg_wr;
    assign reg_wr = bank_wr && (wr_ofs == OFS_W'(i));
    if (i < NUM_MASKED) begin : g_masked
      logic reg_clr;
      if (i == int'(OFS_OE)) begin : g_oe_clr
        assign reg_clr = shutdown;
      end else begin : g_no_clr
        assign reg_clr = 1'b0;
      end
      gpio_masked_reg #(.W(PIN_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_mask (wr_mask),
        .wr_val  (wr_val),
        .clr     (reg_clr),
        .q       (reg_q[i])
      );
    end else begin : g_plain
      gpio_masked_reg #(.W(PIN_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_mask ({PIN_W{1'b1}}),
        .wr_val  (wr_val),
        .clr     (1'b0),
        .q       (reg_q[i])
      );
    end
  end

  gpio_override_mux #(.W(PIN_W)) u_mux (
    .data      (reg_q[OFS_DATA]),
    .sel       (reg_q[OFS_OVSEL]),
    .tx_pat    (reg_q[OFS_OVTX]),
    .rx_pat    (reg_q[OFS_OVRX]),
    .tx_active (tx_active),
    .pin_out   (pin_out)
  );

  assign pin_oe = reg_q[OFS_OE];

  always_comb begin
    rb_state = (pin_oe & pin_out) | (~pin_oe & pin_in);
  end

  // Bits not selected by the override follow the data register.
  assert_ovr_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ reg_q[OFS_DATA]) & ~reg_q[OFS_OVSEL]) == '0);

  // Readback of driven pins shows the output, of tri-stated pins the input.
  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((rb_state ^ pin_out) & pin_oe) == '0) && (((rb_state ^ pin_in) & ~pin_oe) == '0));

  // Override register loads ignore the upper half-word.
  assert_ovr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && wr_ofs == OFS_OVSEL) |=> (reg_q[OFS_OVSEL] == $past(wr_val)));

endmodule

// File: rtl/gpio_tr_top.sv
module gpio_tr_top
  import gpio_tr_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [2*PIN_W-1:0] wr_data,
  input  logic               tx_active,
  input  logic [PIN_W-1:0]   tx_pin_in,
  input  logic [PIN_W-1:0]   rx_pin_in,
  output logic [PIN_W-1:0]   tx_pin_out,
  output logic [PIN_W-1:0]   tx_pin_oe,
  output logic [PIN_W-1:0]   rx_pin_out,
  output logic [PIN_W-1:0]   rx_pin_oe,
  output logic [2*PIN_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] SHUTDOWN_ADDR = '1;
  localparam int BANK_BIT = ADDR_W - 1;

  logic             rst_int_n;
  logic             shutdown;
  logic [PIN_W-1:0] pin_in  [NUM_BANKS];
  logic [PIN_W-1:0] pin_out [NUM_BANKS];
  logic [PIN_W-1:0] pin_oe  [NUM_BANKS];
  logic [PIN_W-1:0] rb      [NUM_BANKS];

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_int_n)
  );

  assign shutdown  = wr_en && (wr_addr == SHUTDOWN_ADDR);
  assign pin_in[0] = tx_pin_in;
  assign pin_in[1] = rx_pin_in;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en && !shutdown && (wr_addr[BANK_BIT] == 1'(b));
    gpio_bank #(.PIN_W(PIN_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .bank_wr   (bank_wr),
      .wr_ofs    (wr_addr[OFS_W-1:0]),
      .wr_data   (wr_data),
      .shutdown  (shutdown),
      .tx_active (tx_active),
      .pin_in    (pin_in[b]),
      .pin_out   (pin_out[b]),
      .pin_oe    (pin_oe[b]),
      .rb_state  (rb[b])
    );
  end

  assign tx_pin_out = pin_out[0];
  assign tx_pin_oe  = pin_oe[0];
  assign rx_pin_out = pin_out[1];
  assign rx_pin_oe  = pin_oe[1];
  assign rd_data    = {rb[1], rb[0]};

  // Shutdown leaves every pin an input.
  assert_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    shutdown |=> (tx_pin_oe == '0 && rx_pin_oe == '0));

  // Writes to unmapped offsets leave directions untouched.
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !shutdown && wr_addr[OFS_W-1:0] > OFS_W'(OFS_OVRX)) |=>
      ($stable(tx_pin_oe) && $stable(rx_pin_oe)));

  // A write to one bank keeps the other bank's direction.
  assert_bank_iso_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !shutdown && wr_addr[BANK_BIT]) |=> $stable(tx_pin_oe));

endmodule

// File: tb/tb_gpio_tr_top.sv
module tb_gpio_tr_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        tx_active;
  logic [15:0] tx_pin_in;
  logic [15:0] rx_pin_in;
  logic [15:0] tx_pin_out, tx_pin_oe, rx_pin_out, rx_pin_oe;
  logic [31:0] rd_data;

  gpio_tr_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_active(tx_active), .tx_pin_in(tx_pin_in),
    .rx_pin_in(rx_pin_in), .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe),
    .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] toe;
    logic [15:0] tout;
    logic [15:0] roe;
    logic [15:0] rout;
    logic [31:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  logic [15:0] m_oe [2];
  logic [15:0] m_io [2];
  logic [15:0] m_sel[2];
  logic [15:0] m_tx [2];
  logic [15:0] m_rx [2];

  function automatic logic [15:0] drv(int b, bit txa);
    return (m_sel[b] & (txa ? m_tx[b] : m_rx[b])) | (~m_sel[b] & m_io[b]);
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    int b;
    b = int'(a[3]);
    if (a == 4'hF) begin
      m_oe[0] = '0;
      m_oe[1] = '0;
    end else begin
      case (a[2:0])
        3'd0: m_oe[b] = (m_oe[b] & ~d[31:16]) | (d[15:0] & d[31:16]);
        3'd1: m_io[b] = (m_io[b] & ~d[31:16]) | (d[15:0] & d[31:16]);
        3'd2: m_sel[b] = d[15:0];
        3'd3: m_tx[b] = d[15:0];
        3'd4: m_rx[b] = d[15:0];
        default: ;
      endcase
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d,
                      input bit txa, input logic [15:0] ti, input logic [15:0] ri,
                      input string tag);
    exp_t e;
    logic [15:0] to, ro;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tx_active = txa;
    tx_pin_in = ti; rx_pin_in = ri;
    if (we) model_write(a, d);
    to = drv(0, txa);
    ro = drv(1, txa);
    e.toe  = m_oe[0];
    e.tout = to;
    e.roe  = m_oe[1];
    e.rout = ro;
    e.rd   = {(m_oe[1] & ro) | (~m_oe[1] & ri), (m_oe[0] & to) | (~m_oe[0] & ti)};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after the edge that applied the stimulus.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {tx_pin_oe, tx_pin_out, rx_pin_oe, rx_pin_out, rd_data};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: actual oe_t=%h out_t=%h oe_r=%h out_r=%h rd=%h expected oe_t=%h out_t=%h oe_r=%h out_r=%h rd=%h",
                 t, got.toe, got.tout, got.roe, got.rout, got.rd,
                 e.toe, e.tout, e.roe, e.rout, e.rd);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_oe[b] = '0; m_io[b] = '0; m_sel[b] = '0; m_tx[b] = '0; m_rx[b] = '0;
    end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tx_active = 1'b0; tx_pin_in = 16'h1234; rx_pin_in = 16'h8765;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, readback shows the inputs
    step(0, 4'h0, 32'h0, 0, 16'h1234, 16'h8765, "R1 reset");
    // R2 masked direction writes
    step(1, 4'h0, 32'h00FF_0F0F, 0, 16'hFFFF, 16'h0000, "R2 oe low byte");
    step(1, 4'h0, 32'hF000_FFFF, 0, 16'hFFFF, 16'h0000, "R2 oe top nibble");
    // R3 masked data writes
    step(1, 4'h1, 32'hFFFF_A5A5, 0, 16'h0000, 16'h0000, "R3 io full");
    step(1, 4'h1, 32'h0F00_0000, 0, 16'h0000, 16'hFFFF, "R3 io partial");
    // R4 receive bank writes leave transmit bank alone
    step(1, 4'h8, 32'hFFFF_00F0, 0, 16'h5555, 16'hAAAA, "R4 rx oe");
    step(1, 4'h9, 32'h00F0_0030, 0, 16'h5555, 16'hAAAA, "R4 rx io");
    // R5 antenna switch override on bit 1 of transmit bank
    step(1, 4'h0, 32'h0002_0002, 0, 16'h0, 16'h0, "R5 enable tr bit");
    step(1, 4'h2, 32'h0000_0002, 0, 16'h0, 16'h0, "R5 ovr sel");
    step(1, 4'h3, 32'h0000_0000, 0, 16'h0, 16'h0, "R5 ovr tx pattern");
    step(1, 4'h4, 32'h0000_0002, 0, 16'h0, 16'h0, "R5 ovr rx pattern");
    step(0, 4'h0, 32'h0, 1, 16'h0, 16'h0, "R5 tx active");
    step(0, 4'h0, 32'h0, 0, 16'h0, 16'h0, "R5 rx active");
    // R6 upper half ignored on override loads
    step(1, 4'hA, 32'hFFFF_F00F, 0, 16'h0, 16'h0, "R6 rx ovr sel");
    step(1, 4'hB, 32'h0000_C003, 1, 16'h0, 16'h0, "R6 rx ovr tx");
    step(1, 4'hC, 32'hFFFF_3001, 1, 16'h0, 16'h0, "R6 rx ovr rx");
    // R7 override leaves direction intact under both states
    step(0, 4'h0, 32'h0, 1, 16'h0F0F, 16'hF0F0, "R7 oe under tx");
    step(0, 4'h0, 32'h0, 0, 16'hF0F0, 16'h0F0F, "R7 oe under rx");
    // R8 readback with varied input patterns
    step(0, 4'h0, 32'h0, 0, 16'hFFFF, 16'hFFFF, "R8 inputs high");
    step(0, 4'h0, 32'h0, 1, 16'h0000, 16'h0000, "R8 inputs low");
    // R10 unmapped offsets
    step(1, 4'h5, 32'hFFFF_FFFF, 0, 16'h0, 16'h0, "R10 addr5");
    step(1, 4'h7, 32'hFFFF_0000, 0, 16'h0, 16'h0, "R10 addr7");
    step(1, 4'hE, 32'hFFFF_FFFF, 0, 16'h0, 16'h0, "R10 addr14");
    // R9 shutdown clears directions, data kept
    step(1, 4'hF, 32'h0, 0, 16'h6789, 16'h9876, "R9 shutdown");
    // R11 re-enable shows retained data on the next cycle
    step(1, 4'h0, 32'hFFFF_FFFF, 0, 16'h0, 16'h0, "R11 reenable tx");
    step(1, 4'h8, 32'hFFFF_FFFF, 1, 16'h0, 16'h0, "R11 reenable rx");
    step(0, 4'h0, 32'h0, 0, 16'h0, 16'h0, "R11 hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule